// File: doc/BRIEF.md
# Big-Endian Sub-Word Data Memory

This block is a synchronous data store of 64-bit words that is addressed by byte. A request can read or write 1, 2, 4 or 8 bytes. The low three address bits select a byte offset inside the word, and the remaining bits select the word. Offset 0 of a narrow access maps to the most significant byte of the word, so narrow fields occupy big-endian byte lanes. Bit 0 of the word is still its least significant bit.

A narrow store reads the current word, replaces only the addressed field and writes the word back. A narrow load returns the addressed field shifted down to bit 0 with the upper bits cleared. An access whose offset is not a multiple of its width is rejected with an error flag. A rejected access leaves memory unchanged.

Both the request and the response are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response is valid from the next cycle. It stays there, unchanged, until it is taken on an edge where `rsp_valid` and `rsp_ready` are both high. The block holds at most one request in flight. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle, so throughput is one access per cycle when the response stream never stalls.

Top module: `sbmem_top`

## Requirements
- R1: The word index is the byte address shifted right by 3 and the byte offset is the low 3 address bits. Different byte addresses within one word act on the same stored word.
- R2: The width code `req_size` selects 1, 2, 4 or 8 bytes for codes 0, 1, 2 and 3.
- R3: An access whose byte offset ANDed with (bytes − 1) is non-zero is misaligned. Its response has `rsp_err`=1 and `rsp_rdata`=0, and memory is not modified.
- R4: An aligned access of N bytes at offset k covers word bits [8·(8−k)−1 : 8·(8−k−N)], so offset 0 is the most significant byte.
- R5: A load returns the addressed field at bits [8N−1:0] with every higher bit zero.
- R6: A narrow store replaces only the addressed field. Bytes outside the field keep their values, and store data above bit 8N−1 is ignored.
- R7: An 8-byte store at offset 0 replaces the whole word.
- R8: Every word that has not been stored to since reset reads back as zero.
- R9: When `rsp_ready` is high, each accepted request yields exactly one response in the next cycle, in request order. Store responses carry `rsp_rdata`=0.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response holds its data and error flag and `req_ready` is low. A stalled store is committed exactly once.
- R11: After reset `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (11) | Byte address |
| req_size | input | 2 | Width code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 64 | Store data, field in the low bits |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 64 | Load field, zero-extended |
| rsp_err | output | 1 | Misaligned access flag |

## Verification
A response is due in the cycle right after its request is accepted. The scoreboard stamps each expected item with that cycle number. Whenever the response stream never stalls, the monitor requires the response to appear in exactly that cycle. During stalled phases only the order and the values are compared, and the monitor also checks that the held response keeps its value on every stalled cycle. The effect of a store is checked through loads issued after the store's response, which are the only point where the written word becomes visible.

// File: rtl/sbmem_pkg.sv
package sbmem_pkg;
  localparam int WORD_BYTES = 8;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int SH_W       = $clog2(WORD_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } size_e;
endpackage

// File: rtl/sbmem_align.sv
module sbmem_align
  import sbmem_pkg::*;
(
  input  logic [OFF_W-1:0]  off,
  input  size_e             size,
  output logic              misal,
  output logic [SH_W-1:0]   shamt,
  output logic [WORD_W-1:0] fmask
);
  logic [OFF_W:0] nbytes;
  logic [OFF_W:0] lanes_below;

  assign nbytes      = (OFF_W+1)'(1) << size;
  assign misal       = (off & OFF_W'(nbytes - 1'b1)) != '0;
  assign lanes_below = (OFF_W+1)'(WORD_BYTES) - nbytes - {1'b0, off};
  assign shamt       = {lanes_below[OFF_W-1:0], 3'b000};
  assign fmask       = (size == SZ_DBL) ? {WORD_W{1'b1}}
                     : ((WORD_W'(1) << {nbytes, 3'b000}) - WORD_W'(1));
endmodule

// File: rtl/sbmem_lane.sv
module sbmem_lane
  import sbmem_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] wdata,
  input  logic [SH_W-1:0]   shamt,
  input  logic [WORD_W-1:0] fmask,
  output logic [WORD_W-1:0] merged,
  output logic [WORD_W-1:0] field
);
  logic [WORD_W-1:0]     pmask;
  logic [WORD_W-1:0]     pdata;
  logic [WORD_BYTES-1:0] ben;

  assign pmask = fmask << shamt;
  assign pdata = (wdata & fmask) << shamt;
  assign field = (old_word >> shamt) & fmask;

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    assign ben[b]          = |pmask[8*b +: 8];
    assign merged[8*b +: 8] = ben[b] ? pdata[8*b +: 8] : old_word[8*b +: 8];
  end
endmodule

// File: rtl/sbmem_store.sv
module sbmem_store
  import sbmem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rword,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wword
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vld <= '0;
    else if (we) vld[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wword;
  end

  assign rword = vld[ridx] ? mem[ridx] : '0;

  // R8
  write_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> vld[$past(widx)]);
endmodule

// File: rtl/sbmem_top.sv
module sbmem_top
  import sbmem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  logic              s1_valid, s1_write;
  logic [IDX_W-1:0]  s1_idx;
  logic [OFF_W-1:0]  s1_off;
  size_e             s1_size;
  logic [WORD_W-1:0] s1_wdata;

  logic              misal;
  logic [SH_W-1:0]   shamt;
  logic [WORD_W-1:0] fmask, cur_word, merged, field;
  logic              req_fire, commit;

  assign req_ready = !s1_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  // request slot: read phase happens while the slot is occupied
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         s1_valid <= 1'b0;
    else if (req_ready) s1_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_write <= 1'b0;
      s1_idx   <= '0;
      s1_off   <= '0;
      s1_size  <= SZ_BYTE;
      s1_wdata <= '0;
    end else if (req_fire) begin
      s1_write <= req_write;
      s1_idx   <= req_addr[ADDR_W-1:OFF_W];
      s1_off   <= req_addr[OFF_W-1:0];
      s1_size  <= size_e'(req_size);
      s1_wdata <= req_wdata;
    end
  end

  sbmem_align u_align (
    .off   (s1_off),
    .size  (s1_size),
    .misal (misal),
    .shamt (shamt),
    .fmask (fmask)
  );

  sbmem_lane u_lane (
    .old_word (cur_word),
    .wdata    (s1_wdata),
    .shamt    (shamt),
    .fmask    (fmask),
    .merged   (merged),
    .field    (field)
  );

  // write phase: commit on the edge the response leaves
  assign commit = s1_valid && rsp_ready && s1_write && !misal;

  sbmem_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .ridx  (s1_idx),
    .rword (cur_word),
    .we    (commit),
    .widx  (s1_idx),
    .wword (merged)
  );

  assign rsp_valid = s1_valid;
  assign rsp_err   = s1_valid && misal;
  assign rsp_rdata = (s1_valid && !misal && !s1_write) ? field : '0;

  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R5
  narrow_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & ~fmask) == '0));

  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0 && !commit));
endmodule

// File: tb/sbmem_top_tb.sv
module sbmem_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH) + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  sbmem_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [63:0] rd;
    logic        err;
    int          due;
    bit          timed;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] model [DEPTH];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit bp = 1'b0;

  always @(posedge clk) cyc++;

  // response back-pressure pattern, changed just after each edge
  always @(posedge clk) begin
    #1;
    rsp_ready = bp ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: computes the expected response from the requirements
  task automatic issue(bit wr, int addr, int sz, logic [63:0] d, string req);
    exp_t e;
    int nb, off, idx, sh;
    logic [63:0] m;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    nb = 1 << sz; off = addr % 8; idx = addr / 8;
    e.req = req; e.due = cyc + 1; e.timed = !bp;
    if ((off % nb) != 0) begin          // R3
      e.err = 1'b1; e.rd = '0;
    end else begin
      e.err = 1'b0;
      m  = (nb == 8) ? {64{1'b1}} : ((64'd1 << (nb*8)) - 64'd1);
      sh = (8 - nb - off) * 8;          // R4 big-endian lanes
      if (wr) begin
        model[idx] = (model[idx] & ~(m << sh)) | ((d & m) << sh);
        e.rd = '0;
      end else e.rd = (model[idx] >> sh) & m;
    end
    sb.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(addr);
    req_size = 2'(sz); req_wdata = d;
  endtask

  task automatic drain();
    int guard = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() != 0 && guard < 500) begin
      @(negedge clk); guard++;
    end
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R9: actual %0d pending expected 0", sb.size());
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9: actual extra response expected none");
      end else begin
        check64({sb[0].req, " data"}, rsp_rdata, sb[0].rd);
        check64({sb[0].req, " err"}, 64'(rsp_err), 64'(sb[0].err));
        if (!rsp_ready) check64("R10 req_ready low in stall", 64'(req_ready), 64'd0);
        if (sb[0].timed) check64("R9 response cycle", 64'(cyc), 64'(sb[0].due));
        if (rsp_ready) void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    check64("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check64("R11 req_ready after reset", 64'(req_ready), 64'd1);

    // R8 unwritten words
    issue(0, 0, 3, '0, "R8 unwritten word 0");
    issue(0, 8*200, 3, '0, "R8 unwritten word 200");
    issue(0, 8*77+5, 0, '0, "R8 unwritten byte");
    // R7 full-width replace
    issue(1, 8, 3, 64'h0011_2233_4455_6677, "R7 full store");
    issue(0, 8, 3, '0, "R7 full load");
    issue(1, 8, 3, 64'hFEDC_BA98_7654_3210, "R7 full overwrite");
    issue(0, 8, 3, '0, "R7 full reload");
    // R4 R6 byte stores with junk above the field
    for (int k = 0; k < 8; k++)
      issue(1, 16 + k, 0, 64'hDEAD_BEEF_0000_00A0 + 64'(k), "R6 byte store");
    issue(0, 16, 3, '0, "R4 byte lanes in word");
    // R5 R2 narrow loads of every size
    issue(0, 18, 1, '0, "R5 half load");
    issue(0, 20, 2, '0, "R5 word load");
    issue(0, 23, 0, '0, "R2 byte load");
    issue(0, 16, 2, '0, "R2 upper word load");
    // R6 half merge into existing word
    issue(1, 10, 1, 64'h1234_5678_9ABC_BEEF, "R6 half merge");
    issue(0, 8, 3, '0, "R6 merged word");
    issue(1, 12, 2, 64'hFFFF_FFFF_CAFE_F00D, "R6 word merge");
    issue(0, 8, 3, '0, "R6 merged word 2");
    // R3 misaligned
    issue(1, 10, 2, 64'h1111_1111, "R3 misaligned word store");
    issue(1, 12, 3, 64'h2222_2222, "R3 misaligned dbl store");
    issue(0, 9, 1, '0, "R3 misaligned half load");
    issue(1, 15, 1, 64'h3333, "R3 misaligned half store");
    issue(0, 8, 3, '0, "R3 memory unchanged");
    // R1 top word and aliasing within a word
    issue(1, 8*(DEPTH-1), 3, 64'h8877_6655_4433_2211, "R1 store top word");
    issue(0, 8*(DEPTH-1) + 7, 0, '0, "R1 top word last byte");
    issue(0, 8*(DEPTH-1) + 4, 2, '0, "R1 top word low half");
    issue(0, 8*(DEPTH-1) - 8, 3, '0, "R1 neighbour untouched");
    drain();

    // R10 back-pressure with mixed traffic
    bp = 1'b1;
    for (int n = 0; n < 150; n++) begin
      int a, s;
      a = $urandom % 40;
      s = $urandom % 4;
      issue(($urandom % 2) == 1, a, s, {$urandom, $urandom}, "R10 stalled traffic");
    end
    for (int w = 0; w < 5; w++) issue(0, 8*w, 3, '0, "R10 final words");
    drain();
    bp = 1'b0;
    repeat (2) @(negedge clk);
    for (int w = 0; w < 5; w++) issue(0, 8*w, 3, '0, "R10 words after stalls");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule